// File: doc/BRIEF.md
# Up/Down Event Counter with Overflow Limit

This block counts events on two level inputs. A rising edge on the increment line adds one to a 16-bit count, and a rising edge on the decrement line subtracts one. The block compares each input against the value it held at the previous execution tick. Two strobes act on the count directly: one clears it, and one loads a preset value. The upstream logic has already qualified both strobes, and each lasts a single cycle. All state changes only on clock cycles where the execution-tick enable is high. Between ticks, the outputs hold their values.

An overflow limit is set by a parameter, and a compile-time choice selects one of two policies. In wrapping mode, the count returns to zero on the tick where it would reach the limit, and the overflow flag is high for that one execution period. In latching mode, the count stays at the limit and the flag stays high. While the flag is high, further increments are ignored. The flag clears when a decrement, a clear or a suitable preset load brings the count back below the limit. The overflow limit must be at least 1.

Top module: `evt_counter`

## Requirements
- R1: After synchronous reset, the count and the flag are 0 and the stored history of both inputs is low. On cycles with `tick` low, the count and the flag keep their values, whatever the other inputs do.
- R2: On a tick where `up_in` is high and was low at the previous tick, the count rises by one. Holding `up_in` high over later ticks adds nothing more.
- R3: On a tick with a rising edge on `dn_in` alone, the count drops by one. A decrement at zero leaves the count at zero.
- R4: When `up_in` and `dn_in` both show a rising edge on the same tick, the count is unchanged.
- R5: `clr_cmd` high on a tick sets the count to 0 and the flag to 0 in both modes. It takes precedence over `load_cmd` and over counting.
- R6: `load_cmd` high on a tick, without `clr_cmd`, sets the count to `PRESET`. It takes precedence over any edge on that tick.
- R7: With `WRAP_MODE` = 1, a tick whose result would equal `LIMIT` instead gives a count of 0 and sets `ovf` high until the next tick.
- R8: With `WRAP_MODE` = 0, `ovf` is high exactly while the count is at or above `LIMIT`. While `ovf` is high, increment edges are ignored and a decrement edge lowers the count by one.
- R9: With `WRAP_MODE` = 0, after a load the flag is high exactly when `PRESET` is at or above `LIMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Execution-cycle enable |
| up_in | input | 1 | Increment level input, edge-detected |
| dn_in | input | 1 | Decrement level input, edge-detected |
| clr_cmd | input | 1 | Qualified clear-to-zero strobe |
| load_cmd | input | 1 | Qualified load-preset strobe |
| count | output | CNT_W | Current count |
| ovf | output | 1 | Overflow flag |

## Verification
The inputs are switched between toggling and held-high patterns. This shows whether the design detects edges or only looks at levels. Inputs are also changed while `tick` is low, to show that the history is sampled only at ticks. In wrapping mode, a run up to the limit checks the one-period flag and the return to zero. The tests also send simultaneous edges, and combinations of clear, load and edge, to check the precedence order. Two latching instances that differ only in their preset show whether a load clears or keeps the flag. Increment and decrement edges sent while the flag is high show which kinds of edge the latch lets through.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_INC,
        ST_DEC,
        ST_CLR,
        ST_LOAD
    } step_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic up_edge;
        logic dn_edge;
    } cmd_t;

    // Clear beats load, load beats counting; equal edges cancel.
    function automatic step_e pick_step(cmd_t c, logic up_blocked);
        step_e s;
        if (c.clr)
            s = ST_CLR;
        else if (c.load)
            s = ST_LOAD;
        else if (c.up_edge && c.dn_edge)
            s = ST_HOLD;
        else if (c.up_edge && !up_blocked)
            s = ST_INC;
        else if (c.dn_edge)
            s = ST_DEC;
        else
            s = ST_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/evcnt_edge.sv
module evcnt_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] hist_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                hist_q[i] <= 1'b0;
            else if (tick)
                hist_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~hist_q[i];
    end
endmodule

// File: rtl/evcnt_next.sv
module evcnt_next
    import evcnt_pkg::*;
#(
    parameter int               CNT_W     = 16,
    parameter bit               WRAP_MODE = 1'b1,
    parameter logic [CNT_W-1:0] LIMIT     = 16'd5,
    parameter logic [CNT_W-1:0] PRESET    = 16'd3
) (
    input  logic [CNT_W-1:0] cur,
    input  step_e            step,
    output logic [CNT_W-1:0] nxt,
    output logic             nxt_ovf
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cand;

    always_comb begin
        unique case (step)
            ST_CLR:  cand = '0;
            ST_LOAD: cand = PRESET;
            ST_INC:  cand = (cur == TOP) ? cur : cur + 1'b1;
            ST_DEC:  cand = (cur == '0) ? cur : cur - 1'b1;
            default: cand = cur;
        endcase
    end

    if (WRAP_MODE) begin : g_wrap
        always_comb begin
            if (cand == LIMIT) begin
                nxt     = '0;
                nxt_ovf = 1'b1;
            end else begin
                nxt     = cand;
                nxt_ovf = 1'b0;
            end
        end
    end else begin : g_latch
        always_comb begin
            nxt     = cand;
            nxt_ovf = (cand >= LIMIT);
        end
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evcnt_pkg::*;
#(
    parameter int               CNT_W     = 16,
    parameter bit               WRAP_MODE = 1'b1,
    parameter logic [CNT_W-1:0] LIMIT     = 16'd5,
    parameter logic [CNT_W-1:0] PRESET    = 16'd3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             up_in,
    input  logic             dn_in,
    input  logic             clr_cmd,
    input  logic             load_cmd,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int LINES = 2;

    logic [LINES-1:0] rise;
    cmd_t             cmd;
    step_e            step;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, ovf_d;
    logic             up_blocked;

    evcnt_edge #(.N(LINES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .lvl  ({dn_in, up_in}),
        .rise (rise)
    );

    assign up_blocked = !WRAP_MODE && ovf_q;

    always_comb begin
        cmd.clr     = clr_cmd;
        cmd.load    = load_cmd;
        cmd.up_edge = rise[0];
        cmd.dn_edge = rise[1];
        step        = pick_step(cmd, up_blocked);
    end

    evcnt_next #(
        .CNT_W     (CNT_W),
        .WRAP_MODE (WRAP_MODE),
        .LIMIT     (LIMIT),
        .PRESET    (PRESET)
    ) u_next (
        .cur     (cnt_q),
        .step    (step),
        .nxt     (cnt_d),
        .nxt_ovf (ovf_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
    parameter int               CNT_W     = 16,
    parameter bit               WRAP_MODE = 1'b1,
    parameter logic [CNT_W-1:0] LIMIT     = 16'd5,
    parameter logic [CNT_W-1:0] PRESET    = 16'd3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             clr_cmd,
    input logic             load_cmd,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);
    localparam logic [CNT_W-1:0] LOADED =
        (WRAP_MODE && PRESET == LIMIT) ? '0 : PRESET;

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(count) && $stable(ovf)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_cmd) |=> (count == '0 && !ovf));

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && load_cmd && !clr_cmd) |=> (count == LOADED));

    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (WRAP_MODE && ovf) |-> (count == '0));

    p_latch_flag_r8: assert property (@(posedge clk) disable iff (rst)
        !WRAP_MODE |-> (ovf == (count >= LIMIT)));

    p_latch_block_r8: assert property (@(posedge clk) disable iff (rst)
        (!WRAP_MODE && tick && ovf && !clr_cmd && !load_cmd)
            |=> (count <= $past(count)));
endmodule

bind evt_counter evt_counter_chk #(
    .CNT_W     (CNT_W),
    .WRAP_MODE (WRAP_MODE),
    .LIMIT     (LIMIT),
    .PRESET    (PRESET)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .clr_cmd  (clr_cmd),
    .load_cmd (load_cmd),
    .count    (count),
    .ovf      (ovf)
);

// File: tb/evt_counter_bench.sv
module evt_counter_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic up_in = 1'b0, dn_in = 1'b0, clr_cmd = 1'b0, load_cmd = 1'b0;
    logic [15:0] cnt_w, cnt_a, cnt_b;
    logic        ovf_w, ovf_a, ovf_b;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // wrapping, LIMIT 5, PRESET 3
    evt_counter #(.CNT_W(16), .WRAP_MODE(1'b1), .LIMIT(16'd5), .PRESET(16'd3)) u_evt_counter (
        .clk(clk), .rst(rst), .tick(tick), .up_in(up_in), .dn_in(dn_in),
        .clr_cmd(clr_cmd), .load_cmd(load_cmd), .count(cnt_w), .ovf(ovf_w));
    // latching, LIMIT 4, PRESET 2 (below limit)
    evt_counter #(.CNT_W(16), .WRAP_MODE(1'b0), .LIMIT(16'd4), .PRESET(16'd2)) u_evt_counter_la (
        .clk(clk), .rst(rst), .tick(tick), .up_in(up_in), .dn_in(dn_in),
        .clr_cmd(clr_cmd), .load_cmd(load_cmd), .count(cnt_a), .ovf(ovf_a));
    // latching, LIMIT 4, PRESET 4 (at limit)
    evt_counter #(.CNT_W(16), .WRAP_MODE(1'b0), .LIMIT(16'd4), .PRESET(16'd4)) u_evt_counter_lb (
        .clk(clk), .rst(rst), .tick(tick), .up_in(up_in), .dn_in(dn_in),
        .clr_cmd(clr_cmd), .load_cmd(load_cmd), .count(cnt_b), .ovf(ovf_b));

    // {up, dn, clr, load, expected count[15:0], expected ovf}, wrapping instance
    localparam int NV = 20;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {4'b1000, 16'd1, 1'b0},  // R2 edge
        {4'b0000, 16'd1, 1'b0},
        {4'b1000, 16'd2, 1'b0},  // R2
        {4'b1000, 16'd2, 1'b0},  // R2 held level
        {4'b0000, 16'd2, 1'b0},
        {4'b1000, 16'd3, 1'b0},
        {4'b0100, 16'd2, 1'b0},  // R3
        {4'b1000, 16'd3, 1'b0},
        {4'b0000, 16'd3, 1'b0},
        {4'b1100, 16'd3, 1'b0},  // R4 both edges
        {4'b0000, 16'd3, 1'b0},
        {4'b1000, 16'd4, 1'b0},
        {4'b0000, 16'd4, 1'b0},
        {4'b1000, 16'd0, 1'b1},  // R7 wrap
        {4'b0000, 16'd0, 1'b0},  // R7 one period
        {4'b0001, 16'd3, 1'b0},  // R6
        {4'b1001, 16'd3, 1'b0},  // R6 over up edge
        {4'b0011, 16'd0, 1'b0},  // R5 over load
        {4'b0100, 16'd0, 1'b0},  // R3 floor
        {4'b0000, 16'd0, 1'b0}
    };

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(logic u, logic d, logic c, logic l);
        @(negedge clk);
        up_in = u; dn_in = d; clr_cmd = c; load_cmd = l; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; clr_cmd = 1'b0; load_cmd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up_in = 1'b0; dn_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        chk("R1 reset count", cnt_w, 16'd0);
        chk("R1 reset ovf", {15'd0, ovf_w}, 16'd0);
        chk("R1 reset count latch", cnt_a, 16'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
            chk($sformatf("vec %0d count (R2-R7 table)", i), cnt_w, VEC[i][16:1]);
            chk($sformatf("vec %0d ovf (R7)", i), {15'd0, ovf_w}, {15'd0, VEC[i][0]});
        end

        // R1: activity without tick changes nothing
        step(1'b1, 1'b0, 1'b0, 1'b0);   // count 1
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            up_in = ~up_in; dn_in = ~dn_in; clr_cmd = 1'b1; load_cmd = 1'b1;
        end
        @(negedge clk);
        clr_cmd = 1'b0; load_cmd = 1'b0; up_in = 1'b1; dn_in = 1'b0;
        @(negedge clk);
        chk("R1 idle count", cnt_w, 16'd1);
        step(1'b1, 1'b0, 1'b0, 1'b0);   // history was high at last tick: no edge
        chk("R1 history sampled at tick", cnt_w, 16'd1);

        // latching instances
        do_reset();
        for (int k = 1; k <= 4; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0, 1'b0);
        end
        chk("R8 count at limit", cnt_a, 16'd4);
        chk("R8 flag set", {15'd0, ovf_a}, 16'd1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 up ignored", cnt_a, 16'd4);
        chk("R8 flag held", {15'd0, ovf_a}, 16'd1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 down count", cnt_a, 16'd3);
        chk("R8 flag cleared", {15'd0, ovf_a}, 16'd0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 up again", cnt_a, 16'd4);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 load below limit count", cnt_a, 16'd2);
        chk("R9 load below limit flag", {15'd0, ovf_a}, 16'd0);
        chk("R9 load at limit count", cnt_b, 16'd4);
        chk("R9 load at limit flag", {15'd0, ovf_b}, 16'd1);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 latch clear count", cnt_b, 16'd0);
        chk("R5 latch clear flag", {15'd0, ovf_b}, 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule